// File: doc/BRIEF.md
# SMRAM Access Control Decoder

This block holds the two host-bridge bytes that govern system-management RAM and turns them into routing decisions for two memory views: the ordinary CPU view and the view seen while the processor runs in system-management mode (SMM). Two windows are covered, and both back onto the same 128 KiB of DRAM. The legacy low window is 0xA0000 to 0xBFFFF. The high alias is 0xFEDA0000 to 0xFEDBFFFF.

Configuration writes arrive one byte at a time, each with a byte offset. Two offsets matter. The control byte (default offset 0x9D) carries the open, lock and global-enable fields. The extended control byte (default offset 0x9E) carries the high-enable field. The block also answers lookups. A lookup gives an address and an SMM flag, and one cycle later the block returns a route: DRAM, PCI/VGA, or no claim. Four enable outputs show which alias is switched to RAM in each view.

A small lock state machine guards the control fields. It has two states:
- `LK_OPENABLE`: the state after reset. The fields follow writes.
- `LK_SEALED`: entered by the SEAL transition, which fires when a control-byte write has the lock bit set. The machine leaves this state only through reset.

While sealed, the open field is held at zero and every other field is frozen.

Top module: `smram_gate`

## Requirements
- R1: After reset the control byte reads as 0x02, with open, lock, global-enable and high-enable all 0. All four view enables are 0. A non-SMM lookup of the low window returns route code 2 (PCI). A non-SMM lookup of the high window returns route code 0 (no claim). Route code 1 means DRAM.
- R2: With the open field (bit 6 of the control byte) clear, a non-SMM lookup returns PCI for the low window and no claim for the high window.
- R3: With open set and high-enable (bit 7 of the extended byte) set, a non-SMM lookup returns PCI for the low window and DRAM for the high window.
- R4: With open set and high-enable clear, a non-SMM lookup returns DRAM for the low window and no claim for the high window.
- R5: With global-enable (bit 3 of the control byte) set and high-enable clear, an SMM lookup returns DRAM for the low window. An SMM lookup of the high window gets the non-SMM answer.
- R6: With global-enable and high-enable both set, an SMM lookup returns DRAM for the high window. An SMM lookup of the low window gets the non-SMM answer.
- R7: With global-enable clear, SMM lookups get the non-SMM answer in both windows.
- R8: Window bounds are inclusive: 0xA0000 to 0xBFFFF, and 0xFEDA0000 to 0xFEDBFFFF. Every address outside both windows returns no claim, whatever the mode.
- R9: A lookup's response appears exactly one cycle after the lookup. A lookup presented in the cycle right after a write already sees the written value.
- R10: Writes to any offset other than the two control bytes change no route.
- R11: Writing the control byte with the lock field (bit 4) set seals the block. Open is forced to 0, including in that same write, and it cannot be set again until reset.
- R12: While sealed, global-enable, high-enable and the lock itself ignore writes. Reset clears the seal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | CFG_AW (8) | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| acc_valid | input | 1 | Lookup request |
| acc_addr | input | ADDR_W (32) | Lookup address |
| acc_smm | input | 1 | Lookup is made in SMM |
| rsp_valid | output | 1 | Route result valid (one cycle after acc_valid) |
| rsp_route | output | 2 | 0 no claim, 1 DRAM, 2 PCI/VGA |
| norm_low_ram | output | 1 | Normal view: low window goes to DRAM |
| norm_high_ram | output | 1 | Normal view: high alias goes to DRAM |
| smm_low_ram | output | 1 | SMM view: low window goes to DRAM |
| smm_high_ram | output | 1 | SMM view: high alias goes to DRAM |

## Verification
A wrong field value or lock state shows up on the four view enables in the cycle after the write that caused it. It also shows up in the route of the next lookup, one cycle later. A seal that is lost or that fires when it should not only becomes visible when a later write tries to reopen the block or change its enables. The bench therefore probes routes after such writes. Off-by-one errors at the window bounds only appear at the first and last byte of each window, so the bench probes the addresses just inside and just outside both bounds.

// File: rtl/smram_pkg.sv
package smram_pkg;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_DRAM = 2'd1,
        RT_PCI  = 2'd2
    } route_e;

    typedef enum logic {
        LK_OPENABLE = 1'b0,
        LK_SEALED   = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic open;
        logic lock;
        logic gbl;
        logic hi;
    } smram_cfg_t;

    typedef struct packed {
        logic norm_low_ram;
        logic norm_high_ram;
        logic smm_low_ram;
        logic smm_high_ram;
    } smram_view_t;

    localparam int unsigned OPEN_BIT = 6;
    localparam int unsigned LOCK_BIT = 4;
    localparam int unsigned GBL_BIT  = 3;
    localparam int unsigned HI_BIT   = 7;

endpackage

// File: rtl/smram_ctrl_regs.sv
module smram_ctrl_regs
    import smram_pkg::*;
#(
    parameter int unsigned    CFG_AW     = 8,
    parameter logic [CFG_AW-1:0] CTRL_OFS = 8'h9D,
    parameter logic [CFG_AW-1:0] EXT_OFS  = 8'h9E,
    parameter logic [7:0]     CTRL_RST   = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output smram_cfg_t        cfg
);

    localparam logic RST_OPEN = CTRL_RST[OPEN_BIT];
    localparam logic RST_GBL  = CTRL_RST[GBL_BIT];

    lock_state_e state_q, state_d;
    logic        open_q, gbl_q, hi_q;
    logic        wr_ctrl, wr_ext;
    logic        unused_bits;

    assign wr_ctrl     = cfg_we && (cfg_addr == CTRL_OFS);
    assign wr_ext      = cfg_we && (cfg_addr == EXT_OFS);
    assign unused_bits = ^{cfg_wdata[5], cfg_wdata[2:0]};

    // Next state of the lock machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPENABLE: if (wr_ctrl && cfg_wdata[LOCK_BIT]) state_d = LK_SEALED;
            LK_SEALED:   state_d = LK_SEALED;
            default:     state_d = LK_OPENABLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_OPENABLE;
        else        state_q <= state_d;
    end

    // Field registers, gated by the lock state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= RST_OPEN;
            gbl_q  <= RST_GBL;
            hi_q   <= 1'b0;
        end else begin
            unique case (state_q)
                LK_OPENABLE: begin
                    if (wr_ctrl) begin
                        open_q <= cfg_wdata[OPEN_BIT] & ~cfg_wdata[LOCK_BIT];
                        gbl_q  <= cfg_wdata[GBL_BIT];
                    end
                    if (wr_ext) hi_q <= cfg_wdata[HI_BIT];
                end
                LK_SEALED: open_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // Output process
    always_comb begin
        cfg.open = open_q;
        cfg.lock = (state_q == LK_SEALED);
        cfg.gbl  = gbl_q;
        cfg.hi   = hi_q;
    end

    assert_lock_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SEALED) |=> (state_q == LK_SEALED));

    assert_sealed_shut_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SEALED) |=> !open_q);

    assert_sealed_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SEALED) |=> ($stable(gbl_q) && $stable(hi_q)));

endmodule

// File: rtl/smram_view_decode.sv
module smram_view_decode
    import smram_pkg::*;
(
    input  smram_cfg_t  cfg,
    output smram_view_t view
);

    logic unused_lock;
    assign unused_lock = cfg.lock;

    always_comb begin
        view.norm_low_ram  = cfg.open & ~cfg.hi;
        view.norm_high_ram = cfg.open &  cfg.hi;
        view.smm_low_ram   = cfg.gbl  & ~cfg.hi;
        view.smm_high_ram  = cfg.gbl  &  cfg.hi;
    end

endmodule

// File: rtl/smram_route_lookup.sv
module smram_route_lookup
    import smram_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]    LOW_BASE  = 32'h000A_0000,
    parameter logic [ADDR_W-1:0]    HIGH_BASE = 32'hFEDA_0000,
    parameter logic [ADDR_W-1:0]    WIN_SIZE  = 32'h0002_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  smram_view_t       view,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    output logic              rsp_valid,
    output logic [1:0]        rsp_route
);

    localparam int unsigned NWIN = 2;
    localparam logic [NWIN*ADDR_W-1:0] BASES = {HIGH_BASE, LOW_BASE};

    logic [NWIN-1:0] hit;
    route_e          norm_low, norm_high, pick;
    route_e          route_q;
    logic            valid_q;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [ADDR_W-1:0] base, offs;
        assign base   = BASES[w*ADDR_W +: ADDR_W];
        assign offs   = acc_addr - base;
        assign hit[w] = (acc_addr >= base) && (offs < WIN_SIZE);
    end

    always_comb begin
        norm_low  = view.norm_low_ram  ? RT_DRAM : RT_PCI;
        norm_high = view.norm_high_ram ? RT_DRAM : RT_NONE;
        pick      = RT_NONE;
        if (hit[0]) begin
            pick = (acc_smm && view.smm_low_ram) ? RT_DRAM : norm_low;
        end else if (hit[1]) begin
            pick = (acc_smm && view.smm_high_ram) ? RT_DRAM : norm_high;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            route_q <= RT_NONE;
        end else begin
            valid_q <= acc_valid;
            if (acc_valid) route_q <= pick;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_route = route_q;

    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    assert_outside_unclaimed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (hit == '0)) |=> (rsp_route == RT_NONE));

    assert_low_always_claimed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && hit[0]) |=> (rsp_route != RT_NONE));

endmodule

// File: rtl/smram_gate.sv
module smram_gate
    import smram_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 32,
    parameter int unsigned          CFG_AW    = 8,
    parameter logic [CFG_AW-1:0]    CTRL_OFS  = 8'h9D,
    parameter logic [CFG_AW-1:0]    EXT_OFS   = 8'h9E,
    parameter logic [7:0]           CTRL_RST  = 8'h02,
    parameter logic [ADDR_W-1:0]    LOW_BASE  = 32'h000A_0000,
    parameter logic [ADDR_W-1:0]    HIGH_BASE = 32'hFEDA_0000,
    parameter logic [ADDR_W-1:0]    WIN_SIZE  = 32'h0002_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    output logic              rsp_valid,
    output logic [1:0]        rsp_route,
    output logic              norm_low_ram,
    output logic              norm_high_ram,
    output logic              smm_low_ram,
    output logic              smm_high_ram
);

    smram_cfg_t  cfg;
    smram_view_t view;

    smram_ctrl_regs #(
        .CFG_AW   (CFG_AW),
        .CTRL_OFS (CTRL_OFS),
        .EXT_OFS  (EXT_OFS),
        .CTRL_RST (CTRL_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    smram_view_decode u_view (
        .cfg  (cfg),
        .view (view)
    );

    smram_route_lookup #(
        .ADDR_W    (ADDR_W),
        .LOW_BASE  (LOW_BASE),
        .HIGH_BASE (HIGH_BASE),
        .WIN_SIZE  (WIN_SIZE)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .view      (view),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_smm   (acc_smm),
        .rsp_valid (rsp_valid),
        .rsp_route (rsp_route)
    );

    assign norm_low_ram  = view.norm_low_ram;
    assign norm_high_ram = view.norm_high_ram;
    assign smm_low_ram   = view.smm_low_ram;
    assign smm_high_ram  = view.smm_high_ram;

    assert_one_smm_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(smm_low_ram && smm_high_ram));

    assert_sealed_no_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.lock |-> !(norm_low_ram || norm_high_ram));

endmodule

// File: tb/smram_gate_tb.sv
`timescale 1ns/1ps
module smram_gate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_smm = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_route;
    logic        norm_low_ram, norm_high_ram, smm_low_ram, smm_high_ram;

    always #4 clk = ~clk;

    smram_gate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_smm(acc_smm), .rsp_valid(rsp_valid), .rsp_route(rsp_route),
        .norm_low_ram(norm_low_ram), .norm_high_ram(norm_high_ram),
        .smm_low_ram(smm_low_ram), .smm_high_ram(smm_high_ram)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [1:0] q_exp[$];
    string      q_tag[$];

    bit m_open, m_lock, m_g, m_h;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] model_route(logic [31:0] a, logic smm);
        logic [1:0] nl, nh;
        nl = (m_open && !m_h) ? 2'd1 : 2'd2;
        nh = (m_open &&  m_h) ? 2'd1 : 2'd0;
        if (a >= 32'h000A_0000 && a <= 32'h000B_FFFF)
            return (smm && m_g && !m_h) ? 2'd1 : nl;
        if (a >= 32'hFEDA_0000 && a <= 32'hFEDB_FFFF)
            return (smm && m_g && m_h) ? 2'd1 : nh;
        return 2'd0;
    endfunction

    task automatic model_reset();
        m_open = 0; m_lock = 0; m_g = 0; m_h = 0;
    endtask

    task automatic model_write(logic [7:0] ofs, logic [7:0] d);
        if (ofs == 8'h9D && !m_lock) begin
            m_lock = d[4]; m_open = d[6] & ~d[4]; m_g = d[3];
        end
        if (ofs == 8'h9E && !m_lock) m_h = d[7];
    endtask

    task automatic check_views(string tag);
        check(tag, {norm_low_ram, norm_high_ram, smm_low_ram, smm_high_ram},
              {m_open & ~m_h, m_open & m_h, m_g & ~m_h, m_g & m_h});
    endtask

    task automatic cfg_write(logic [7:0] ofs, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(ofs, d);
    endtask

    task automatic probe(logic [31:0] a, logic smm, string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_smm = smm;
        q_exp.push_back(model_route(a, smm));
        q_tag.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Write followed by a lookup in the very next cycle
    task automatic write_then_probe(logic [7:0] ofs, logic [7:0] d,
                                    logic [31:0] a, logic smm, string tag);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(ofs, d);
        acc_valid = 1'b1; acc_addr = a; acc_smm = smm;
        q_exp.push_back(model_route(a, smm));
        q_tag.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_exp.size() == 0) begin
                check("R9 spurious response", 32'd1, 32'd0);
            end else begin
                logic [1:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(t, {30'd0, rsp_route}, {30'd0, e});
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        model_reset();
        do_reset();
        @(negedge clk);
        check("R1 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
        check_views("R1 view enables after reset");

        probe(32'h000A_0000, 0, "R1 low normal");
        probe(32'hFEDA_0000, 0, "R1 high normal");
        probe(32'h000B_0000, 1, "R7 low smm gbl clear");
        probe(32'hFEDB_0000, 1, "R7 high smm gbl clear");

        probe(32'h0009_FFFF, 0, "R8 below low");
        probe(32'h000C_0000, 1, "R8 above low");
        probe(32'h000B_FFFF, 0, "R8 low last byte");
        probe(32'hFED9_FFFF, 0, "R8 below high");
        probe(32'hFEDC_0000, 1, "R8 above high");
        probe(32'h0000_1000, 1, "R8 unrelated");

        cfg_write(8'h9D, 8'h40);
        check_views("R4 views open");
        probe(32'h000A_0000, 0, "R4 low open");
        probe(32'hFEDA_0000, 0, "R4 high open");

        cfg_write(8'h9E, 8'h80);
        check_views("R3 views open hi");
        probe(32'h000A_1234, 0, "R3 low open hi");
        probe(32'hFEDB_FFFF, 0, "R3 high open hi");
        probe(32'hFEDC_0000, 0, "R8 above high open hi");

        cfg_write(8'h9D, 8'h08);
        check_views("R6 views gbl hi");
        probe(32'hFEDA_0100, 1, "R6 smm high");
        probe(32'h000A_0100, 1, "R6 smm low follows normal");
        probe(32'hFEDA_0100, 0, "R2 high normal closed");
        probe(32'h000A_0100, 0, "R2 low normal closed");

        cfg_write(8'h9E, 8'h00);
        check_views("R5 views gbl");
        probe(32'h000B_FFFF, 1, "R5 smm low");
        probe(32'hFEDA_0000, 1, "R5 smm high follows normal");
        probe(32'h000B_FFFF, 0, "R5 normal low");

        cfg_write(8'h9C, 8'hFF);
        cfg_write(8'h9F, 8'hFF);
        check_views("R10 views after foreign writes");
        probe(32'h000A_0000, 0, "R10 low normal");
        probe(32'hFEDA_0000, 1, "R10 high smm");

        write_then_probe(8'h9D, 8'h48, 32'h000A_0000, 0, "R9 next-cycle low");
        write_then_probe(8'h9D, 8'h08, 32'h000A_0000, 0, "R9 next-cycle closed");

        cfg_write(8'h9D, 8'h58);
        check_views("R11 views sealed");
        probe(32'h000A_0000, 0, "R11 low after seal");
        cfg_write(8'h9D, 8'h40);
        probe(32'h000A_0000, 0, "R11 reopen ignored");

        cfg_write(8'h9E, 8'h80);
        probe(32'hFEDA_0000, 1, "R12 hi write ignored");
        probe(32'h000A_0000, 1, "R12 smm low kept");
        cfg_write(8'h9D, 8'h00);
        check_views("R12 views frozen");
        probe(32'h000A_0000, 1, "R12 gbl clear ignored");

        repeat (3) @(negedge clk);
        do_reset();
        @(negedge clk);
        check_views("R1 views after second reset");
        cfg_write(8'h9D, 8'h40);
        probe(32'h000A_0000, 0, "R12 reset clears seal");

        repeat (4) @(negedge clk);
        check("R9 pending responses", q_exp.size(), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule